// File: doc/BRIEF.md
# Coder Output Stream Parser with Differential Coding

This block sits directly behind a transform source coder in a video multiplexer. The coder delivers one byte at a time together with a 4-bit type tag and a strobe. The parser latches an item when it sees a rising strobe edge. It follows the fixed order of items inside each macroblock and drops anything that arrives out of turn. Each accepted item becomes a tagged output item. Most field values pass straight through. The macroblock number and the two motion vector components are replaced by the differential values that an H.261 bitstream carries.

Downstream, a variable-length coder consumes the output items. It uses the end-of-sub-block marker to close each block of run/level pairs. A macroblock tick is also produced, which a controller can count to follow progress through the picture.

The sequencing state machine has ten states:
- `S_IDLE`: waits for the first control byte after reset.
- `S_GRP`, `S_MBN`, `S_PAT`, `S_QNT`, `S_MVX`, `S_MVY`: each expects exactly one header item, in this order: group, macroblock number, pattern, quantiser, horizontal vector, vertical vector.
- `S_SUB`: waits for a sub-block number.
- `S_RUN`: waits for a zero-run byte.
- `S_LVL`: waits for a coefficient.

Transitions:
- An accepted control byte moves any state to `S_GRP`.
- Each accepted header item moves to the next header state.
- `S_MVY` moves to `S_SUB`.
- `S_SUB` moves to `S_RUN`.
- `S_RUN` moves to `S_LVL`.
- `S_LVL` returns to `S_SUB` if the run before it carried the end marker, and to `S_RUN` otherwise.

Top module: `coder_stream_parser`

## Requirements
- R1: During reset and after it, until the first accepted item, `item_valid`, `item_eob` and `mb_tick` are 0.
- R2: An item is accepted only at a clock edge where `src_strobe` is 1 and was 0 at the previous edge. Its output appears for exactly one cycle, registered at that same edge. A strobe held high yields only one item.
- R3: Tag codes are: 0 group, 1 macroblock number, 2 control, 3 quantiser, 4 horizontal vector, 5 vertical vector, 6 pattern, 7 sub-block, 8 zero run, 9 coefficient. Codes 10 to 15 are ignored, including 15 (wait). A tag other than the one the current state expects is ignored and leaves the state unchanged. `item_kind` equals the tag of the accepted item.
- R4: A control byte is accepted in any state. Its value is output with bits 4 and 7 forced to 0. Its bit 3 marks the macroblock as motion compensated.
- R5: Field values are zero-extended to 8 bits: group from data[3:0], quantiser from data[4:0], sub-block from data[2:0], zero run from data[5:0]. The pattern is output as data[6:1], so value bit 5 flags sub-block 1 and bit 0 flags sub-block 6. A coefficient passes through unchanged.
- R6: The macroblock item's value is the 8-bit two's-complement difference between data[5:0] and the previous accepted macroblock number. The previous number is 0 after reset and is reset to 0 when a group item carries a number different from the last group item (the first group item always counts as new).
- R7: A vector item in a motion-compensated macroblock outputs (data[4:0] − predictor), wrapped to −16..+15 and sign-extended to 8 bits. In a non-compensated macroblock it outputs 0. The predictor then becomes the new vector, or 0 if the macroblock is not compensated.
- R8: Both predictors are reset to 0 when a new group starts (as in R6), and when a macroblock number of 1, 12 or 23 is accepted.
- R9: A zero-run byte with data[7:6] = 11 sets `item_eob` with its output. After the following coefficient, the parser waits for a sub-block number. Otherwise it waits for another zero run.
- R10: A control byte that arrives in the middle of a macroblock abandons that macroblock and restarts the header sequence at the group item.
- R11: `mb_tick` is high for exactly 3 cycles. It rises at the 6th clock edge after the edge that accepted a macroblock number item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_strobe | input | 1 | Data strobe from the source coder; an item is taken on its rising edge |
| src_tag | input | 4 | Type tag of the byte on `src_data` |
| src_data | input | 8 | Data byte from the source coder |
| item_valid | output | 1 | One-cycle pulse for each accepted item |
| item_kind | output | 4 | Tag of the output item |
| item_value | output | 8 | Decoded or differential value |
| item_eob | output | 1 | End of sub-block, given with a zero-run item |
| mb_tick | output | 1 | Three-cycle macroblock pulse |

## Verification
The bench targets the following corner cases:
- Vector pairs that force the wrap: a predictor of +15 followed by a vector of −15. A design that does not wrap would output −30 instead of +2.
- Macroblock numbers 1, 12 and 23, and repeated versus changed group numbers. A design that resets its predecessors on every group item would output the absolute macroblock number instead of the difference.
- Out-of-turn tags, unused tags and a strobe held high. A design that accepts these would emit extra items or lose its place in the sequence.
- A control byte in the middle of a header, and a zero coefficient after an end marker. These check that the state machine restarts correctly and returns to the sub-block wait.

// File: rtl/csp_pkg.sv
package csp_pkg;

    localparam int BYTE_W = 8;
    localparam int TAG_W  = 4;

    typedef enum logic [TAG_W-1:0] {
        TG_GROUP   = 4'h0,
        TG_MBNUM   = 4'h1,
        TG_CTRL    = 4'h2,
        TG_QUANT   = 4'h3,
        TG_MVX     = 4'h4,
        TG_MVY     = 4'h5,
        TG_PATTERN = 4'h6,
        TG_SUBBLK  = 4'h7,
        TG_RUN     = 4'h8,
        TG_LEVEL   = 4'h9,
        TG_WAIT    = 4'hF
    } tag_e;

    typedef enum logic [3:0] {
        S_IDLE, S_GRP, S_MBN, S_PAT, S_QNT, S_MVX, S_MVY, S_SUB, S_RUN, S_LVL
    } pstate_e;

    localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'h6F;
    localparam int                MC_BIT    = 3;

endpackage

// File: rtl/csp_strobe_edge.sv
module csp_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_i;
    end

    assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/csp_mv_pred.sv
module csp_mv_pred #(
    parameter int MV_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            upd_i,
    input  logic            mc_i,
    input  logic [MV_W-1:0] mv_i,
    output logic [MV_W-1:0] diff_o
);
    logic [MV_W-1:0] pred_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       pred_q <= '0;
        else if (clear_i) pred_q <= '0;
        else if (upd_i)   pred_q <= mc_i ? mv_i : '0;
    end

    // modular subtraction at MV_W bits gives the -16..+15 wrap
    assign diff_o = mc_i ? (mv_i - pred_q) : '0;
endmodule

// File: rtl/csp_tick_gen.sv
module csp_tick_gen #(
    parameter int DELAY = 6,
    parameter int LEN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic tick_o
);
    localparam int LAST  = DELAY + LEN;
    localparam int CNT_W = $clog2(LAST + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt >= CNT_W'(DELAY)) && (cnt < CNT_W'(LAST));
            if (start_i)                    cnt <= CNT_W'(1);
            else if (cnt == CNT_W'(LAST))   cnt <= '0;
            else if (cnt != '0)             cnt <= cnt + 1'b1;
        end
    end

    assert_tick_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (cnt != '0));
endmodule

// File: rtl/coder_stream_parser.sv
module coder_stream_parser
    import csp_pkg::*;
#(
    parameter int MV_W       = 5,
    parameter int MBA_W      = 6,
    parameter int GRP_W      = 4,
    parameter int TICK_DELAY = 6,
    parameter int TICK_LEN   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_strobe,
    input  logic [3:0] src_tag,
    input  logic [7:0] src_data,
    output logic       item_valid,
    output logic [3:0] item_kind,
    output logic [7:0] item_value,
    output logic       item_eob,
    output logic       mb_tick
);
    localparam int NUM_MV = 2;

    pstate_e            state, nxt_state;
    logic               rise, accept;
    logic               mc_q, eob_q, gob_seen;
    logic [GRP_W-1:0]   gob_q;
    logic [MBA_W-1:0]   prev_mba;
    logic               grp_new, mba_anchor, mv_clear;
    logic [7:0]         value_mux;
    logic [MV_W-1:0]    mv_diff [NUM_MV];

    csp_strobe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .strobe_i(src_strobe), .rise_o(rise)
    );

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt_state;
    end

    always_comb begin
        accept    = 1'b0;
        nxt_state = state;
        if (rise) begin
            if (src_tag == TG_CTRL) begin
                accept    = 1'b1;
                nxt_state = S_GRP;
            end else begin
                unique case (state)
                    S_GRP: if (src_tag == TG_GROUP)   begin accept = 1'b1; nxt_state = S_MBN; end
                    S_MBN: if (src_tag == TG_MBNUM)   begin accept = 1'b1; nxt_state = S_PAT; end
                    S_PAT: if (src_tag == TG_PATTERN) begin accept = 1'b1; nxt_state = S_QNT; end
                    S_QNT: if (src_tag == TG_QUANT)   begin accept = 1'b1; nxt_state = S_MVX; end
                    S_MVX: if (src_tag == TG_MVX)     begin accept = 1'b1; nxt_state = S_MVY; end
                    S_MVY: if (src_tag == TG_MVY)     begin accept = 1'b1; nxt_state = S_SUB; end
                    S_SUB: if (src_tag == TG_SUBBLK)  begin accept = 1'b1; nxt_state = S_RUN; end
                    S_RUN: if (src_tag == TG_RUN)     begin accept = 1'b1; nxt_state = S_LVL; end
                    S_LVL: if (src_tag == TG_LEVEL) begin
                        accept    = 1'b1;
                        nxt_state = eob_q ? S_SUB : S_RUN;
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- differential context ----------------
    assign grp_new    = accept && (src_tag == TG_GROUP) &&
                        (!gob_seen || (src_data[GRP_W-1:0] != gob_q));
    assign mba_anchor = accept && (src_tag == TG_MBNUM) &&
                        ((src_data[MBA_W-1:0] == MBA_W'(1))  ||
                         (src_data[MBA_W-1:0] == MBA_W'(12)) ||
                         (src_data[MBA_W-1:0] == MBA_W'(23)));
    assign mv_clear   = grp_new || mba_anchor;

    for (genvar c = 0; c < NUM_MV; c++) begin : g_mv
        localparam tag_e MY_TAG = (c == 0) ? TG_MVX : TG_MVY;
        csp_mv_pred #(.MV_W(MV_W)) u_pred (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear_i(mv_clear),
            .upd_i  (accept && (src_tag == MY_TAG)),
            .mc_i   (mc_q),
            .mv_i   (src_data[MV_W-1:0]),
            .diff_o (mv_diff[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q     <= 1'b0;
            eob_q    <= 1'b0;
            gob_seen <= 1'b0;
            gob_q    <= '0;
            prev_mba <= '0;
        end else if (accept) begin
            if (src_tag == TG_CTRL) mc_q <= src_data[MC_BIT];
            if (src_tag == TG_RUN)  eob_q <= &src_data[7:6];
            if (src_tag == TG_GROUP) begin
                gob_seen <= 1'b1;
                gob_q    <= src_data[GRP_W-1:0];
                if (grp_new) prev_mba <= '0;
            end
            if (src_tag == TG_MBNUM) prev_mba <= src_data[MBA_W-1:0];
        end
    end

    // ---------------- value selection ----------------
    always_comb begin
        value_mux = src_data;
        unique case (src_tag)
            TG_CTRL:    value_mux = src_data & CTRL_KEEP;
            TG_GROUP:   value_mux = 8'(src_data[GRP_W-1:0]);
            TG_MBNUM:   value_mux = 8'(src_data[MBA_W-1:0]) - 8'(prev_mba);
            TG_PATTERN: value_mux = {2'b00, src_data[6:1]};
            TG_QUANT:   value_mux = {3'b000, src_data[4:0]};
            TG_MVX:     value_mux = {{(8-MV_W){mv_diff[0][MV_W-1]}}, mv_diff[0]};
            TG_MVY:     value_mux = {{(8-MV_W){mv_diff[1][MV_W-1]}}, mv_diff[1]};
            TG_SUBBLK:  value_mux = {5'b00000, src_data[2:0]};
            TG_RUN:     value_mux = {2'b00, src_data[5:0]};
            default:    value_mux = src_data;
        endcase
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            item_valid <= 1'b0;
            item_kind  <= '0;
            item_value <= '0;
            item_eob   <= 1'b0;
        end else begin
            item_valid <= accept;
            item_kind  <= src_tag;
            item_value <= value_mux;
            item_eob   <= accept && (src_tag == TG_RUN) && (&src_data[7:6]);
        end
    end

    csp_tick_gen #(.DELAY(TICK_DELAY), .LEN(TICK_LEN)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(accept && (src_tag == TG_MBNUM)),
        .tick_o (mb_tick)
    );

    // ---------------- assertions ----------------
    assert_valid_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        item_valid |-> $past(rise));

    assert_kind_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
        item_valid |-> (item_kind <= 4'd9));

    assert_eob_on_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        item_eob |-> (item_valid && item_kind == TG_RUN));

    assert_mvd_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (item_valid && (item_kind == TG_MVX || item_kind == TG_MVY)) |->
        ((item_value[7:MV_W-1] == '0) || (item_value[7:MV_W-1] == '1)));
endmodule

// File: tb/coder_stream_parser_tb.sv
module coder_stream_parser_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_strobe = 1'b0;
    logic [3:0] src_tag = 4'hF;
    logic [7:0] src_data = 8'h00;
    logic       item_valid, item_eob, mb_tick;
    logic [3:0] item_kind;
    logic [7:0] item_value;

    int checks = 0, fails = 0, cyc = 0, cap_k = 0;
    bit have_cap = 0, done = 0;

    // bench model state
    int m_state = 0, m_prev = 0, m_ph = 0, m_pv = 0, m_gob = 0;
    bit m_mc = 0, m_gseen = 0, m_eob = 0;

    coder_stream_parser u_dut (
        .clk(clk), .rst_n(rst_n), .src_strobe(src_strobe), .src_tag(src_tag),
        .src_data(src_data), .item_valid(item_valid), .item_kind(item_kind),
        .item_value(item_value), .item_eob(item_eob), .mb_tick(mb_tick)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h @%0t", rq, act, exp, $time);
        end
    endtask

    function automatic int wrap5(input int d);
        if (d > 15)  return d - 32;
        if (d < -16) return d + 32;
        return d;
    endfunction

    // independent expectation from the requirements
    task automatic model(input logic [3:0] t, input logic [7:0] d,
                         output bit ev, output logic [7:0] val, output bit ee);
        int n, v, df;
        ev = 0; val = 0; ee = 0;
        if (t == 4'd2) begin
            ev = 1; val = d & 8'h6F; m_mc = d[3]; m_state = 1;
        end else begin
            case (m_state)
                1: if (t == 4'd0) begin
                    ev = 1; val = {4'b0, d[3:0]};
                    if (!m_gseen || int'(d[3:0]) != m_gob) begin m_prev = 0; m_ph = 0; m_pv = 0; end
                    m_gseen = 1; m_gob = int'(d[3:0]); m_state = 2;
                end
                2: if (t == 4'd1) begin
                    n = int'(d[5:0]); v = n - m_prev; ev = 1; val = v[7:0];
                    m_prev = n;
                    if (n == 1 || n == 12 || n == 23) begin m_ph = 0; m_pv = 0; end
                    m_state = 3;
                end
                3: if (t == 4'd6) begin ev = 1; val = {2'b0, d[6:1]}; m_state = 4; end
                4: if (t == 4'd3) begin ev = 1; val = {3'b0, d[4:0]}; m_state = 5; end
                5, 6: if (t == (m_state == 5 ? 4'd4 : 4'd5)) begin
                    ev = 1;
                    v = $signed(d[4:0]);
                    if (m_mc) begin
                        df = wrap5(v - (m_state == 5 ? m_ph : m_pv));
                        if (m_state == 5) m_ph = v; else m_pv = v;
                    end else begin
                        df = 0;
                        if (m_state == 5) m_ph = 0; else m_pv = 0;
                    end
                    val = df[7:0];
                    m_state = (m_state == 5) ? 6 : 7;
                end
                7: if (t == 4'd7) begin ev = 1; val = {5'b0, d[2:0]}; m_state = 8; end
                8: if (t == 4'd8) begin
                    ev = 1; val = {2'b0, d[5:0]}; ee = &d[7:6]; m_eob = ee; m_state = 9;
                end
                9: if (t == 4'd9) begin ev = 1; val = d; m_state = m_eob ? 7 : 8; end
                default: ;
            endcase
        end
    endtask

    task automatic send(input logic [3:0] t, input logic [7:0] d, input string rq);
        bit ev, ee; logic [7:0] val;
        model(t, d, ev, val, ee);
        @(negedge clk); src_tag = t; src_data = d; src_strobe = 1'b1;
        @(negedge clk);
        chk(item_valid == ev && (!ev || (item_kind == t && item_value == val && item_eob == ee)),
            rq, {item_valid, item_kind, item_value, item_eob}, {ev, t, val, ee});
        if (ev && t == 4'd1) begin cap_k = cyc; have_cap = 1; end
        src_strobe = 1'b0;
    endtask

    // R11: tick monitor from capture cycle
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            automatic bit exp_t = have_cap && (cyc - cap_k) >= 6 && (cyc - cap_k) <= 8;
            chk(mb_tick == exp_t, "R11", mb_tick, exp_t);
        end
    end

    task automatic send_mb(input int grp, input int mbn, input bit mc, input int mvx, input int mvy, input bit inject);
        logic [5:0] pat;
        send(4'd2, {1'b0, 1'b0, 1'b0, 1'b0, mc, 1'b0, 1'b1, 1'b0} | 8'($urandom_range(0, 255) & 8'h97), "R4");
        send(4'd0, 8'(grp) | 8'hA0, "R6");
        send(4'd1, 8'(mbn) | 8'hC0, "R6");
        pat = 6'($urandom_range(1, 63));
        send(4'd6, {1'b1, pat, 1'b1}, "R5");
        if (inject) begin
            send(4'd9, 8'($urandom), "R3");
            send(4'($urandom_range(10, 15)), 8'($urandom), "R3");
        end
        send(4'd3, 8'($urandom_range(1, 31)) | 8'hE0, "R5");
        send(4'd4, 8'(mvx & 31), "R7");
        send(4'd5, 8'(mvy & 31), "R8");
        for (int b = 0; b < 6; b++) begin
            if (pat[5-b]) begin
                send(4'd7, 8'(b + 1) | 8'hF8, "R5");
                for (int p = 0; p < int'($urandom_range(0, 2)); p++) begin
                    send(4'd8, 8'($urandom_range(0, 63)), "R5");
                    send(4'd9, 8'($urandom_range(1, 255)), "R5");
                end
                send(4'd8, 8'hC0 | 8'($urandom_range(0, 63)), "R9");
                send(4'd9, ($urandom_range(0, 1) != 0) ? 8'h00 : 8'($urandom), "R9");
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk(item_valid == 0 && item_eob == 0 && mb_tick == 0, "R1", {item_valid, item_eob, mb_tick}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(item_valid == 0 && item_eob == 0 && mb_tick == 0, "R1", {item_valid, item_eob, mb_tick}, 0);

        // R3: items before any control byte are dropped
        send(4'd0, 8'h03, "R3");
        send(4'd1, 8'h05, "R3");
        // wait tag without strobe
        @(negedge clk); src_tag = 4'hF;
        @(negedge clk); chk(item_valid == 0, "R3", item_valid, 0);

        // R2: strobe held high gives one item
        begin
            bit ev, ee; logic [7:0] val;
            model(4'd2, 8'hFF, ev, val, ee);
            @(negedge clk); src_tag = 4'd2; src_data = 8'hFF; src_strobe = 1'b1;
            @(negedge clk); chk(item_valid && item_value == val, "R2", {item_valid, item_value}, {1'b1, val});
            @(negedge clk); chk(item_valid == 0, "R2", item_valid, 0);
            @(negedge clk); chk(item_valid == 0, "R2", item_valid, 0);
            src_strobe = 1'b0;
        end
        // R10: restart in mid header
        send(4'd0, 8'h02, "R10");
        send(4'd2, 8'h08, "R10");
        send(4'd1, 8'h04, "R10");  // out of turn, dropped
        send(4'd0, 8'h02, "R10");

        // directed wrap: +15 then -15, same group, compensated
        send_mb(5, 5, 1, 15, -15, 0);
        send_mb(5, 6, 1, -15, 15, 0);
        send_mb(5, 7, 0, 9, 9, 0);    // not compensated -> 0
        send_mb(5, 8, 1, 3, -4, 0);   // predictor was zeroed
        send_mb(5, 12, 1, 2, 2, 0);   // anchor MB
        send_mb(5, 13, 1, 7, 7, 0);
        send_mb(5, 15, 1, 1, 1, 0);   // same group: difference kept
        send_mb(6, 3, 1, 4, 4, 0);    // new group: predecessors reset

        // random macroblock streams
        for (int g = 1; g <= 4; g++) begin
            int mbn = 0;
            for (int k = 0; k < 8; k++) begin
                mbn += $urandom_range(1, 4);
                if (mbn > 33) break;
                send_mb(g, mbn, $urandom_range(0, 3) != 0,
                        int'($urandom_range(0, 30)) - 15, int'($urandom_range(0, 30)) - 15,
                        $urandom_range(0, 3) == 0);
            end
        end

        repeat (12) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule